// File: doc/BRIEF.md
# Hub Packet Repeater Connectivity Controller

This block decides, one microframe at a time, which way a high-speed hub repeater carries traffic. It receives already-decoded single-cycle event pulses. The upstream side supplies validated start-of-packet and end-of-packet pulses. Each downstream port supplies its own start and end pulses. A frame timer supplies two end-of-frame markers, the early one (EOF1) and the late one (EOF2). A flag reports that the hub is locked to frame timing, and a second flag reports that the elasticity buffer has drained. From these the block drives the repeat direction, the two path enables, and a one-cycle request to disable a downstream port.

The controller has four states. The first waits for traffic from upstream only. The second carries an upstream packet to the downstream ports. The third waits for a packet from either side. The fourth carries one downstream port's packet upstream. A connection stays open after its end-of-packet until the buffer has drained. Either end-of-frame marker sends the controller back to the upstream-only wait. A downstream port that is still sending when EOF2 arrives is flagged for disabling.

Top module: `hub_rptr_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `state_o` is 0, `dir_o` is 0, both path enables are low, `owner_o` is 0 and `port_kill` is all zero. State codes: 0 = wait for upstream start, 1 = repeating upstream packet, 2 = wait for start from either side, 3 = repeating downstream packet.
- R2: An upstream start pulse in state 0 or state 2 gives state 1 on the next cycle. In state 1, `dir_o` is 1 (downstream-bound) and `dn_path_en` is high. `dir_o` is 0 in states 0 and 2, and 2 (upstream-bound) in state 3.
- R3: State 1 is left only once an upstream end pulse has been seen and `buf_empty` is high; these may occur in the same cycle or in later cycles. The controller then goes to state 2 if `sof_locked` is high, and to state 0 otherwise.
- R4: A downstream start in state 2 gives state 3 with `dir_o` = 2 and `up_path_en` high. `owner_o` latches the lowest-numbered port that is starting.
- R5: In state 3, only the owner's end pulse counts. The controller returns to state 2 once that pulse has been seen and `buf_empty` is high.
- R6: EOF1 or EOF2 sends the controller to state 0 on the next cycle from any state, overriding every other event. An end pulse still waiting for the buffer to drain is discarded.
- R7: EOF2 in state 3 raises `port_kill` for one cycle, as a one-hot vector with the owner's bit set. EOF1 in state 3, and EOF2 in any other state, leave `port_kill` at zero.
- R8: Downstream start pulses have no effect in state 0 or state 1.
- R9: If an upstream start and a downstream start arrive together in state 2, the upstream start wins and `owner_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_sop | input | 1 | Validated start of packet from upstream (pulse) |
| up_eop | input | 1 | End of packet from upstream (pulse) |
| dn_sop | input | N_DN | Validated start of packet, one bit per downstream port |
| dn_eop | input | N_DN | End of packet, one bit per downstream port |
| eof1 | input | 1 | Early end-of-frame marker (pulse) |
| eof2 | input | 1 | Late end-of-frame marker (pulse) |
| sof_locked | input | 1 | Hub is locked to frame timing |
| buf_empty | input | 1 | Elasticity buffer has repeated its last bit |
| state_o | output | 2 | Current state code |
| dir_o | output | 2 | Repeat direction: 0 none, 1 downstream-bound, 2 upstream-bound |
| dn_path_en | output | 1 | Enable for the upstream-to-downstream path |
| up_path_en | output | 1 | Enable for the downstream-to-upstream path |
| owner_o | output | IDX_W | Index of the downstream port holding the connection |
| port_kill | output | N_DN | One-cycle one-hot request to disable a port |

## Verification
The hardest case to reach is an end pulse that is still waiting for the buffer to drain when a frame marker cuts it off. If it were not cleared, a later packet would close as soon as the buffer drains. The stimulus reaches this case by opening an upstream packet, sending its end pulse with the buffer not empty, firing EOF1, and then opening a new packet and raising `buf_empty` with no end pulse. The connection must stay open. The same sequence style drives EOF2 against a downstream owner with a high port number, and a two-port simultaneous start, to check the one-hot disable vector and the port priority.

// File: rtl/hub_rptr_pkg.sv
// Shared types for the hub repeater connectivity controller.
// Assumes: the state codes are visible at the top's ports, so the values are fixed.
package hub_rptr_pkg;
    typedef enum logic [1:0] {
        ST_UP_SOP  = 2'd0,
        ST_UP_EOP  = 2'd1,
        ST_ANY_SOP = 2'd2,
        ST_DN_EOP  = 2'd3
    } rptr_state_t;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_UP   = 2'd2
    } rptr_dir_t;
endpackage

// File: rtl/hub_rptr_arb.sv
// Fixed-priority picker over downstream start pulses.
// Picks the lowest-numbered active request; purely combinational.
// Assumes: N_DN >= 1 and IDX_W wide enough to hold N_DN-1.
module hub_rptr_arb #(
    parameter int N_DN  = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_DN-1:0]  req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top index down so that the lowest index wins.
    always_comb begin
        idx = '0;
        for (int i = N_DN - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Any request present.
    assign hit = |req;
endmodule

// File: rtl/hub_rptr_drain.sv
// Teardown qualifier: holds an end-of-packet until the elasticity buffer drains.
// done is high in the cycle where an end pulse (now or earlier) meets an empty buffer.
// Assumes: flush clears any held end pulse; it takes priority over new ones.
module hub_rptr_drain (
    input  logic clk,
    input  logic rst_n,
    input  logic eop_in,
    input  logic buf_empty,
    input  logic flush,
    output logic done
);
    logic held;

    // Teardown is allowed once an end pulse exists and the buffer is empty.
    assign done = (eop_in | held) & buf_empty;

    // Remember an end pulse that arrived before the buffer drained.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || done) held <= 1'b0;
        else if (eop_in)             held <= 1'b1;
    end
endmodule

// File: rtl/hub_rptr_fsm.sv
// Four-state microframe connectivity sequencer with owner latch and port-kill request.
// Assumes: events are single-cycle pulses; drain_done already contains buffer drain.
module hub_rptr_fsm
    import hub_rptr_pkg::*;
#(
    parameter int N_DN  = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_sop,
    input  logic             dn_hit,
    input  logic [IDX_W-1:0] dn_idx,
    input  logic             drain_done,
    input  logic             eof1,
    input  logic             eof2,
    input  logic             sof_locked,
    output rptr_state_t      state,
    output logic [IDX_W-1:0] owner,
    output logic [N_DN-1:0]  kill
);
    rptr_state_t      nxt;
    logic             frame_end;
    logic             take_dn;
    logic             kill_now;
    logic [N_DN-1:0]  owner_hot;

    assign frame_end = eof1 | eof2;
    assign take_dn   = !frame_end && state == ST_ANY_SOP && !up_sop && dn_hit;
    assign kill_now  = eof2 && state == ST_DN_EOP;

    // Next-state selection; frame markers override every other event.
    always_comb begin
        nxt = state;
        if (frame_end) begin
            nxt = ST_UP_SOP;
        end else begin
            case (state)
                ST_UP_SOP:  if (up_sop) nxt = ST_UP_EOP;
                ST_UP_EOP:  if (drain_done) nxt = sof_locked ? ST_ANY_SOP : ST_UP_SOP;
                ST_ANY_SOP: begin
                    if (up_sop)      nxt = ST_UP_EOP;
                    else if (dn_hit) nxt = ST_DN_EOP;
                end
                ST_DN_EOP:  if (drain_done) nxt = ST_ANY_SOP;
                default:    nxt = ST_UP_SOP;
            endcase
        end
    end

    // One-hot form of the owner index, one bit per port.
    for (genvar p = 0; p < N_DN; p++) begin : g_hot
        assign owner_hot[p] = (owner == IDX_W'(p));
    end

    // State, owner and kill registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_UP_SOP;
            owner <= '0;
            kill  <= '0;
        end else begin
            state <= nxt;
            if (take_dn) owner <= dn_idx;
            kill <= kill_now ? owner_hot : '0;
        end
    end

    // R6: a frame marker always lands in the upstream-only wait.
    a_r6_frame_home: assert property (@(posedge clk) disable iff (!rst_n)
        (eof1 || eof2) |=> state == ST_UP_SOP);

    // R7: at most one port is killed, and only as the controller returns home.
    a_r7_kill_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(kill));
    a_r7_kill_home: assert property (@(posedge clk) disable iff (!rst_n)
        (|kill) |-> state == ST_UP_SOP);

    // R9: an upstream start in the general wait never opens a downstream connection.
    a_r9_up_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ANY_SOP && up_sop && !eof1 && !eof2) |=> state == ST_UP_EOP && $stable(owner));
endmodule

// File: rtl/hub_rptr_ctl.sv
// Top of the hub repeater connectivity controller.
// Routes end pulses for the open connection to the drain qualifier, picks a
// downstream owner, and turns the state into direction and path enables.
// Assumes: all event inputs are validated single-cycle pulses in the clk domain.
module hub_rptr_ctl
    import hub_rptr_pkg::*;
#(
    parameter int N_DN  = 4,
    localparam int IDX_W = (N_DN > 1) ? $clog2(N_DN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_sop,
    input  logic             up_eop,
    input  logic [N_DN-1:0]  dn_sop,
    input  logic [N_DN-1:0]  dn_eop,
    input  logic             eof1,
    input  logic             eof2,
    input  logic             sof_locked,
    input  logic             buf_empty,
    output logic [1:0]       state_o,
    output logic [1:0]       dir_o,
    output logic             dn_path_en,
    output logic             up_path_en,
    output logic [IDX_W-1:0] owner_o,
    output logic [N_DN-1:0]  port_kill
);
    rptr_state_t      st;
    rptr_dir_t        dir;
    logic             dn_hit;
    logic [IDX_W-1:0] dn_idx;
    logic             eop_sel;
    logic             drain_done;

    hub_rptr_arb #(.N_DN(N_DN), .IDX_W(IDX_W)) u_arb (
        .req (dn_sop),
        .hit (dn_hit),
        .idx (dn_idx)
    );

    // Only the end pulse of the side that holds the connection counts.
    always_comb begin
        case (st)
            ST_UP_EOP: eop_sel = up_eop;
            ST_DN_EOP: eop_sel = dn_eop[owner_o];
            default:   eop_sel = 1'b0;
        endcase
    end

    hub_rptr_drain u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .eop_in    (eop_sel),
        .buf_empty (buf_empty),
        .flush     (eof1 | eof2),
        .done      (drain_done)
    );

    hub_rptr_fsm #(.N_DN(N_DN), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_sop     (up_sop),
        .dn_hit     (dn_hit),
        .dn_idx     (dn_idx),
        .drain_done (drain_done),
        .eof1       (eof1),
        .eof2       (eof2),
        .sof_locked (sof_locked),
        .state      (st),
        .owner      (owner_o),
        .kill       (port_kill)
    );

    // Direction follows the state directly.
    always_comb begin
        case (st)
            ST_UP_EOP: dir = DIR_DOWN;
            ST_DN_EOP: dir = DIR_UP;
            default:   dir = DIR_NONE;
        endcase
    end

    assign state_o    = st;
    assign dir_o      = dir;
    assign dn_path_en = (dir == DIR_DOWN);
    assign up_path_en = (dir == DIR_UP);

    // R2: the two paths are never enabled together.
    a_r2_paths_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_path_en && up_path_en));

    // R3: an upstream connection stays open while the buffer still holds bits.
    a_r3_wait_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UP_EOP && !buf_empty && !eof1 && !eof2) |=> st == ST_UP_EOP);

    // R5: a downstream connection and its owner hold while the buffer still holds bits.
    a_r5_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DN_EOP && !buf_empty && !eof1 && !eof2) |=> st == ST_DN_EOP && $stable(owner_o));

    // R8: downstream starts cannot move the controller out of the upstream-only wait.
    a_r8_up_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_UP_SOP && !up_sop) |=> st == ST_UP_SOP);
endmodule

// File: tb/tb_hub_rptr_ctl.sv
// Bench: one table of single-cycle stimulus and expected outputs, then directed reset checks.
module tb_hub_rptr_ctl;
    localparam int N  = 4;
    localparam int IW = 2;
    localparam int NV = 35;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_sop = 0, up_eop = 0, eof1 = 0, eof2 = 0, sof_locked = 0, buf_empty = 1;
    logic [N-1:0]  dn_sop = '0, dn_eop = '0;
    logic [1:0]    state_o, dir_o;
    logic          dn_path_en, up_path_en;
    logic [IW-1:0] owner_o;
    logic [N-1:0]  port_kill;

    int n_cmp = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hub_rptr_ctl #(.N_DN(N)) dut (
        .clk(clk), .rst_n(rst_n), .up_sop(up_sop), .up_eop(up_eop),
        .dn_sop(dn_sop), .dn_eop(dn_eop), .eof1(eof1), .eof2(eof2),
        .sof_locked(sof_locked), .buf_empty(buf_empty), .state_o(state_o),
        .dir_o(dir_o), .dn_path_en(dn_path_en), .up_path_en(up_path_en),
        .owner_o(owner_o), .port_kill(port_kill)
    );

    // Vector: {req, up_sop, up_eop, dn_sop, dn_eop, eof1, eof2, lock, bufe, st, dir, own, kill}
    function automatic logic [27:0] vec(int rq, bit us, bit ue, logic [3:0] ds, logic [3:0] de,
                                        bit e1, bit e2, bit lk, bit be,
                                        int st, int dr, int ow, logic [3:0] kl);
        return {4'(rq), us, ue, ds, de, e1, e2, lk, be, 2'(st), 2'(dr), 2'(ow), kl};
    endfunction

    localparam logic [27:0] TBL [NV] = '{
        vec(8, 0,0,4'b0001,4'b0000, 0,0,0,1, 0,0,0,4'b0000), // R8 ignored at home
        vec(2, 1,0,4'b0000,4'b0000, 0,0,0,1, 1,1,0,4'b0000), // R2 open downstream
        vec(8, 0,0,4'b0010,4'b0000, 0,0,0,1, 1,1,0,4'b0000), // R8 ignored mid-packet
        vec(3, 0,1,4'b0000,4'b0000, 0,0,0,0, 1,1,0,4'b0000), // R3 eop, buffer busy
        vec(3, 0,0,4'b0000,4'b0000, 0,0,0,0, 1,1,0,4'b0000), // R3 still busy
        vec(3, 0,0,4'b0000,4'b0000, 0,0,0,1, 0,0,0,4'b0000), // R3 drained, unlocked
        vec(2, 1,0,4'b0000,4'b0000, 0,0,1,1, 1,1,0,4'b0000),
        vec(3, 0,1,4'b0000,4'b0000, 0,0,1,1, 2,0,0,4'b0000), // R3 locked
        vec(4, 0,0,4'b0110,4'b0000, 0,0,1,1, 3,2,1,4'b0000), // R4 lowest of 1,2
        vec(5, 0,0,4'b0000,4'b0100, 0,0,1,1, 3,2,1,4'b0000), // R5 foreign eop
        vec(5, 0,0,4'b0000,4'b0010, 0,0,1,0, 3,2,1,4'b0000), // R5 own eop, busy
        vec(5, 0,0,4'b0000,4'b0000, 0,0,1,1, 2,0,1,4'b0000), // R5 drained
        vec(9, 1,0,4'b1000,4'b0000, 0,0,1,1, 1,1,1,4'b0000), // R9 upstream wins
        vec(3, 0,1,4'b0000,4'b0000, 0,0,1,1, 2,0,1,4'b0000),
        vec(4, 0,0,4'b1000,4'b0000, 0,0,1,1, 3,2,3,4'b0000),
        vec(7, 0,0,4'b0000,4'b0000, 0,1,1,1, 0,0,3,4'b1000), // R7 kill port 3
        vec(7, 0,0,4'b0000,4'b0000, 0,0,1,1, 0,0,3,4'b0000), // R7 single cycle
        vec(2, 1,0,4'b0000,4'b0000, 0,0,1,1, 1,1,3,4'b0000),
        vec(6, 0,1,4'b0000,4'b0000, 1,0,1,1, 0,0,3,4'b0000), // R6 eof1 beats eop
        vec(2, 1,0,4'b0000,4'b0000, 0,0,1,1, 1,1,3,4'b0000),
        vec(3, 0,1,4'b0000,4'b0000, 0,0,1,1, 2,0,3,4'b0000),
        vec(6, 0,0,4'b0000,4'b0000, 1,0,1,1, 0,0,3,4'b0000), // R6 eof1 in general wait
        vec(2, 1,0,4'b0000,4'b0000, 0,0,1,1, 1,1,3,4'b0000),
        vec(3, 0,1,4'b0000,4'b0000, 0,0,1,1, 2,0,3,4'b0000),
        vec(4, 0,0,4'b0100,4'b0000, 0,0,1,1, 3,2,2,4'b0000),
        vec(7, 0,0,4'b0000,4'b0000, 1,0,1,1, 0,0,2,4'b0000), // R7 eof1 no kill
        vec(6, 1,0,4'b0000,4'b0000, 0,1,1,1, 0,0,2,4'b0000), // R6 eof2 beats sop
        vec(2, 1,0,4'b0000,4'b0000, 0,0,1,1, 1,1,2,4'b0000),
        vec(3, 0,1,4'b0000,4'b0000, 0,0,1,0, 1,1,2,4'b0000),
        vec(6, 0,0,4'b0000,4'b0000, 1,0,1,0, 0,0,2,4'b0000), // R6 flush held eop
        vec(2, 1,0,4'b0000,4'b0000, 0,0,1,1, 1,1,2,4'b0000),
        vec(6, 0,0,4'b0000,4'b0000, 0,0,1,1, 1,1,2,4'b0000), // R6 stale eop gone
        vec(3, 0,1,4'b0000,4'b0000, 0,0,1,1, 2,0,2,4'b0000),
        vec(4, 0,0,4'b0011,4'b0000, 0,0,1,1, 3,2,0,4'b0000), // R4 port 0 wins
        vec(7, 0,0,4'b0000,4'b0000, 0,1,1,1, 0,0,0,4'b0001)  // R7 kill port 0
    };

    task automatic cmp(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag, int st, int dr, int ow, int kl);
        cmp({tag, " state"}, int'(state_o), st);
        cmp({tag, " dir"}, int'(dir_o), dr);
        cmp({tag, " dn_en"}, int'(dn_path_en), int'(dr == 1));
        cmp({tag, " up_en"}, int'(up_path_en), int'(dr == 2));
        cmp({tag, " owner"}, int'(owner_o), ow);
        cmp({tag, " kill"}, int'(port_kill), kl);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state while held and right after release.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 held", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_all("R1 released", 0, 0, 0, 0);

        // Table walk: drive at negedge, one edge, sample at the next negedge.
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = TBL[i];
            {up_sop, up_eop, dn_sop, dn_eop, eof1, eof2, sof_locked, buf_empty} = v[23:10];
            @(posedge clk);
            @(negedge clk);
            up_sop = 0; up_eop = 0; dn_sop = '0; dn_eop = '0; eof1 = 0; eof2 = 0;
            check_all($sformatf("R%0d step %0d", int'(v[27:24]), i),
                      int'(v[9:8]), int'(v[7:6]), int'(v[5:4]), int'(v[3:0]));
        end

        // R1: reset in the middle of a downstream connection.
        up_sop = 1;
        @(posedge clk); @(negedge clk);
        up_sop = 0; up_eop = 1;
        @(posedge clk); @(negedge clk);
        up_eop = 0; dn_sop = 4'b0100;
        @(posedge clk); @(negedge clk);
        dn_sop = '0;
        check_all("R4 before reset", 3, 2, 2, 0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check_all("R1 mid-connection", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check_all("R1 after re-release", 0, 0, 0, 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule